// File: doc/BRIEF.md
# Chopped-Conversion Demodulating Averager

This block sits behind the decimation filter of an incremental delta-sigma converter whose analog front end has a system-level input chopper. It drives that chopper's polarity for each conversion. The polarity follows a fixed four-step sequence that repeats. The block removes the chopping digitally: it multiplies each returned conversion by its sign, then combines the four most recent demodulated results into one output word. Residual offset is cancelled, and so is a linear drift in that offset. The output rate is half the input rate.

Conversions arrive on a valid/ready stream. Results leave on a second valid/ready stream. The output word is held in a register for a serial shifter to read. Back-pressure works as follows. While a result is pending and the consumer holds `out_ready` low, `in_ready` drops. In that state no conversion is taken and the chopper sequence does not advance. Because of this, no result is ever lost or overwritten. `in_ready` is high whenever no result is pending or the pending one is being taken in the same cycle.

Top module: `chop_ma_demod`

## Requirements
- R1: While reset is asserted and after it is released, before any input: `chop_pol` = 1, `out_valid` = 0, `out_data` = 0, `in_ready` = 1.
- R2: `chop_pol` gives the polarity for the next accepted conversion. Over accepted conversions it follows 1,0,0,1 and repeats. It advances only when an input handshake completes (`in_valid` and `in_ready` both high at a clock edge).
- R3: Each accepted conversion is demodulated as +x when its polarity was 1 and as -x when it was 0. x is two's complement, and the most negative input is handled without overflow.
- R4: An output word is floor((S+2)/4), where S is the sum of the last four demodulated conversions. This is division by four with halves rounded toward plus infinity.
- R5: The first result is produced by the 4th accepted conversion, and each further result by every 2nd accepted conversion after that (the 6th, 8th and so on). `out_valid` is high in the cycle after that input handshake.
- R6: Suppose every input is p·v + a, or p·v + a + b·n, with p = +1/-1 as the polarity, a constant offset a, a constant slope b and conversion index n. Then every output equals v exactly.
- R7: `out_data` changes only when a new result is produced. After an output handshake, `out_valid` goes low unless a new result is produced in that same cycle.
- R8: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. An input offered then is not taken and leaves `chop_pol` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion result offered |
| in_ready | output | 1 | Conversion result can be taken |
| in_data | input | DW | Signed conversion result |
| chop_pol | output | 1 | Input chopper polarity for the next conversion (1 = direct, 0 = swapped) |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DW+1 | Signed demodulated, rounded average |

## Verification
The hardest situation to reach is an input offered while a result is still pending, just as the next result would be formed. That is the only moment the stall must freeze both the chopper sequence and the partly filled four-sample window. The stimulus gets there by holding `out_ready` low with high probability while inputs arrive back to back. Separate phases feed chopped offset plus ramp patterns, extreme two's-complement values and values that sit on a rounding half. These show the cancellation and rounding at the ports.

// File: rtl/chop_ma_pkg.sv
package chop_ma_pkg;
  // number of conversions combined per output word
  localparam int unsigned GROUP = 4;
  localparam int unsigned STEP_W = $clog2(GROUP);

  // polarity of the chop sequence 1,0,0,1 at a given step
  function automatic logic step_polarity(input logic [STEP_W-1:0] s);
    return (s == '0) || (s == STEP_W'(GROUP - 1));
  endfunction
endpackage

// File: rtl/chop_step_gen.sv
module chop_step_gen
  import chop_ma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [STEP_W-1:0] step,
  output logic              pol
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else if (adv) step <= step + 1'b1;
  end

  assign pol = step_polarity(step);

  // R2
  chop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pol));

  // R2
  chop_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !pol) |=> (pol != $past(step[0])));
endmodule

// File: rtl/demod_window.sv
module demod_window #(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift,
  input  logic                   pol,
  input  logic [DW-1:0]          din,
  output logic signed [DW+2:0]   sum
);
  localparam int VW   = DW + 1;
  localparam int SW   = DW + 3;
  localparam int HIST = chop_ma_pkg::GROUP - 1;

  logic signed [VW-1:0] ext;
  logic signed [VW-1:0] cur;
  logic signed [VW-1:0] hist [HIST];

  assign ext = {din[DW-1], din};
  assign cur = pol ? ext : -ext;

  for (genvar i = 0; i < HIST; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist[i] <= '0;
      else if (shift) hist[i] <= (i == 0) ? cur : hist[(i == 0) ? 0 : i-1];
    end
  end

  always_comb begin
    sum = SW'(cur);
    for (int i = 0; i < HIST; i++) sum = sum + SW'(hist[i]);
  end
endmodule

// File: rtl/round_out.sv
module round_out #(
  parameter int SW = 19,
  parameter int OW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [SW-1:0] sum,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [OW-1:0]        out_data
);
  logic signed [SW-1:0] biased;
  logic signed [SW-1:0] quarter;

  assign biased  = sum + SW'(2);
  assign quarter = biased >>> 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= quarter[OW-1:0];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(out_data));
endmodule

// File: rtl/chop_ma_demod.sv
module chop_ma_demod
  import chop_ma_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          chop_pol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW:0]   out_data
);
  localparam int SW = DW + 3;
  localparam int OW = DW + 1;

  logic              in_fire;
  logic              emit;
  logic              warm;
  logic [STEP_W-1:0] step;
  logic signed [SW-1:0] sum;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  // a result on every odd step once a full group has been seen
  assign emit     = in_fire && step[0] && (warm || step == STEP_W'(GROUP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 1'b0;
    else if (in_fire && step == STEP_W'(GROUP - 1)) warm <= 1'b1;
  end

  chop_step_gen u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (in_fire),
    .step (step),
    .pol  (chop_pol)
  );

  demod_window #(.DW(DW)) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .shift(in_fire),
    .pol  (chop_pol),
    .din  (in_data),
    .sum  (sum)
  );

  round_out #(.SW(SW), .OW(OW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (emit),
    .sum      (sum),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  // R8
  stall_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(chop_pol));

  // R5
  out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R5
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !step[0]) |=> !$rose(out_valid));
endmodule

// File: tb/sim_chop_ma_demod.sv
module sim_chop_ma_demod;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic chop_pol;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW:0] out_data;

  int checks = 0;
  int errors = 0;
  int n;
  int hist [4];
  int expq [$];
  int last_pushed;
  int cv, ca, cb;
  bit emitted_prev;

  always #4 clk = ~clk;

  chop_ma_demod #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .chop_pol(chop_pol), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int floor_quarter(input int s);
    int t, q;
    t = s + 2;
    q = t / 4;
    if (t < 0 && (t % 4) != 0) q = q - 1;
    return q;
  endfunction

  function automatic int gen(input int mode, input int p);
    case (mode)
      0: return int'($signed(16'($urandom)));
      1: return p * cv + ca;
      2: return p * cv + ca + cb * n;
      3: return (p == 1) ? -32768 : 32767;
      4: return (p == 1) ? 0 : 7;
      default: return int'($urandom % 9) - 4;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    // R1 during reset
    chk("R1 pol in reset", int'(chop_pol), 1);
    chk("R1 valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 after release
    chk("R1 pol", int'(chop_pol), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_data", int'($signed(out_data)), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    n = 0;
    for (int i = 0; i < 4; i++) hist[i] = 0;
    expq.delete();
    last_pushed = 0;
    emitted_prev = 1'b0;
  endtask

  task automatic cycle(input int mode, input int vprob, input int rprob);
    int p, x, d, s, q, got;
    bit inf, outf;
    @(negedge clk);
    out_ready = (($urandom % 100) < rprob);
    in_valid  = (($urandom % 100) < vprob);
    p = ((n % 4) == 0 || (n % 4) == 3) ? 1 : -1;
    x = gen(mode, p);
    in_data = x[DW-1:0];
    #1;
    // R8 ready rule
    chk("R8 in_ready", int'(in_ready), int'(!(out_valid && !out_ready)));
    // R7 data held between results
    chk("R7 out_data held", int'($signed(out_data)), last_pushed);
    // R5 latency
    if (emitted_prev) chk("R5 out_valid after result", int'(out_valid), 1);
    emitted_prev = 1'b0;
    outf = out_valid && out_ready;
    inf  = in_valid && in_ready;
    if (outf) begin
      got = int'($signed(out_data));
      if (expq.size() == 0) chk("R5 unexpected result", 1, 0);
      else chk("R3 R4 result", got, expq.pop_front());
      // R6 offset and ramp cancellation
      if (mode == 1 || mode == 2) chk("R6 cancel", got, cv);
    end else if (out_valid == 1'b0) begin
      chk("R7 no pending", expq.size(), 0);
    end
    if (inf) begin
      // R2 polarity sequence
      chk("R2 chop_pol", int'(chop_pol), (p == 1) ? 1 : 0);
      d = p * x;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
      n++;
      if (n >= 4 && (n % 2) == 0) begin
        s = hist[0] + hist[1] + hist[2] + hist[3];
        q = floor_quarter(s);
        expq.push_back(q);
        last_pushed = q;
        emitted_prev = 1'b1;
      end
    end
  endtask

  task automatic phase(input int mode, input int cycles, input int vprob, input int rprob);
    do_reset();
    cv = int'($urandom % 2001) - 1000;
    ca = int'($urandom % 2001) - 1000;
    cb = int'($urandom % 41) - 20;
    for (int i = 0; i < cycles; i++) cycle(mode, vprob, rprob);
  endtask

  initial begin
    void'($urandom(32'd7719));
    phase(0, 800, 70, 60);
    phase(0, 800, 95, 15);   // heavy stall: R8 freeze
    phase(1, 600, 80, 80);
    phase(2, 600, 90, 50);
    phase(3, 200, 100, 100);
    phase(4, 200, 60, 90);
    phase(5, 600, 80, 40);
    // R7 final: a pending result stays while consumer waits
    do_reset();
    for (int i = 0; i < 6; i++) cycle(0, 100, 0);
    chk("R8 stalled in_ready", int'(in_ready), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule